// File: doc/BRIEF.md
# In-band Xon/Xoff flow control engine

This block applies character-based (Xon/Xoff) flow control to one serial channel. On the receive side it sits between the byte stream coming out of the deserializer and the receive FIFO. It recognises the configured Xon and Xoff characters, removes them from the data, and turns them into a transmit-halt flag. On the transmit side it sits between the transmit FIFO and the shifter. There it gates FIFO bytes while the halt flag is set, and it injects Xon or Xoff characters when the surrounding logic asks for them.

Four character registers hold two Xon and two Xoff codes. A 4-bit mode field selects the behaviour. Bits 1:0 choose what the receiver matches. Bits 3:2 choose what the transmitter sends. When all four bits are set, the receiver requires a two-character sequence before it acts. While it waits for the second character, it holds one byte. If the second byte does not complete the sequence, the held byte is released as data.

All three byte paths use valid/ready handshakes. A transfer happens on a rising clock edge where both valid and ready are high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value and `rx_ready` is low. `rx_ready` may depend on `rx_valid` and `rx_data` within the same cycle. On the transmit side, `tx_valid` and `tx_data` are combinational from the FIFO side and from the pending flow character. The flow requests and the halt flag are plain level signals.

Top module: `inband_flow_ctrl`

## Requirements
- R1: With mode bits 1:0 = 00, every received byte is forwarded unchanged and in order, and `tx_halt` is low from the first clock edge after that mode is seen.
- R2: With mode bits 1:0 = 01, a received byte equal to `off1_chr` or `on1_chr` is consumed and not forwarded. The first sets `tx_halt` and the second clears it, from the following edge. Bytes equal to `on2_chr` or `off2_chr` are forwarded as data.
- R3: With mode bits 1:0 = 10, the same rule applies with `on2_chr`/`off2_chr` as the active pair, and `on1_chr`/`off1_chr` are forwarded as data.
- R4: With mode bits 1:0 = 11 and bits 3:2 not 11, either Xon code clears `tx_halt` and either Xoff code sets it. All four codes are consumed.
- R5: With mode = 1111, `on1_chr` immediately followed by `on2_chr` clears `tx_halt`, and `off1_chr` followed by `off2_chr` sets it. Neither byte is forwarded, and the first byte alone does not change `tx_halt`.
- R6: In mode 1111, if the byte after a held first character does not complete the sequence, the held byte is forwarded first. The new byte is then evaluated as a fresh byte: it is forwarded, or it is held if it is itself a first character.
- R7: While `out_valid` is high and `out_ready` is low, `out_data` is stable and `rx_ready` is low.
- R8: While `tx_halt` is high and no flow character is pending, `fifo_ready` and `tx_valid` are low. FIFO bytes resume once `tx_halt` clears.
- R9: A pulse on `send_on_req` or `send_off_req` queues a flow character. Mode bits 3:2 = 01 send `on1_chr`/`off1_chr`, 10 send `on2_chr`/`off2_chr`, and 11 send the pair `on1_chr` then `on2_chr` (or `off1_chr` then `off2_chr`). With 00 the requests are ignored. If both requests arrive together, Xoff wins.
- R10: A pending flow character is offered on `tx_valid`/`tx_data` ahead of any FIFO byte, and also while `tx_halt` is high. `fifo_ready` stays low until it has been sent.
- R11: After reset, `out_valid`, `tx_halt` and any pending flow character are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 4 | Bits 3:2 transmit mode, bits 1:0 receive mode |
| on1_chr | input | 8 | First Xon code |
| on2_chr | input | 8 | Second Xon code |
| off1_chr | input | 8 | First Xoff code |
| off2_chr | input | 8 | Second Xoff code |
| rx_valid | input | 1 | Received byte valid |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts the received byte |
| out_valid | output | 1 | Filtered byte valid toward the receive FIFO |
| out_data | output | 8 | Filtered byte |
| out_ready | input | 1 | Receive FIFO accepts the byte |
| send_on_req | input | 1 | Pulse: queue an Xon transmission |
| send_off_req | input | 1 | Pulse: queue an Xoff transmission |
| fifo_valid | input | 1 | Transmit FIFO has a byte |
| fifo_data | input | 8 | Transmit FIFO head byte |
| fifo_ready | output | 1 | Head byte taken by the shifter |
| tx_valid | output | 1 | Byte offered to the shifter |
| tx_data | output | 8 | Byte to shift out |
| tx_ready | input | 1 | Shifter starts a new byte |
| tx_halt | output | 1 | Transmit halted by a received Xoff |

## Verification
The following rules are checked by assertions on every cycle:
- the output stays stable under back-pressure;
- `tx_halt` clears whenever receive flow control is off;
- a single-character Xoff halts the transmitter;
- a lone first character of a sequence leaves the halt flag unchanged;
- a released held byte appears on the output;
- a pending flow character shuts out FIFO bytes;
- the halt flag blocks the FIFO;
- a pair transmission advances to its second character.

Other behaviours are visible only through the bench's scenarios: which codes each receive mode consumes or forwards, the order of a released byte and the byte that follows it, and the exact characters sent in each transmit mode.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
  typedef enum logic [1:0] {
    RXM_OFF = 2'b00,
    RXM_ONE = 2'b01,
    RXM_TWO = 2'b10,
    RXM_ANY = 2'b11
  } rx_mode_e;

  typedef enum logic [1:0] {
    TXM_OFF  = 2'b00,
    TXM_ONE  = 2'b01,
    TXM_TWO  = 2'b10,
    TXM_PAIR = 2'b11
  } tx_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'b00,
    SQ_ON   = 2'b01,
    SQ_OFF  = 2'b10
  } seq_st_e;
endpackage

// File: rtl/ifc_rx_filter.sv
module ifc_rx_filter
  import ifc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rx_mode_e     mode,
  input  logic         pair_seq,
  input  logic [W-1:0] on1,
  input  logic [W-1:0] on2,
  input  logic [W-1:0] off1,
  input  logic [W-1:0] off2,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  output logic         halt
);
  seq_st_e      st_q;
  logic [W-1:0] held_q;
  logic         halt_q;
  logic         ov_q;
  logic [W-1:0] od_q;

  logic         seq_on;
  logic         slot_free;
  logic [W-1:0] want2;
  logic         miss;
  logic         take;
  logic         hit_on;
  logic         hit_off;
  logic         is_ctrl;

  assign seq_on    = pair_seq && (mode == RXM_ANY);
  assign slot_free = !ov_q || out_ready;
  assign want2     = (st_q == SQ_ON) ? on2 : off2;
  assign miss      = seq_on && (st_q != SQ_IDLE) && in_valid && (in_data != want2);
  assign in_ready  = slot_free && !miss;
  assign take      = in_valid && in_ready;

  always_comb begin
    hit_on  = 1'b0;
    hit_off = 1'b0;
    unique case (mode)
      RXM_ONE: begin
        hit_on  = (in_data == on1);
        hit_off = (in_data == off1);
      end
      RXM_TWO: begin
        hit_on  = (in_data == on2);
        hit_off = (in_data == off2);
      end
      RXM_ANY: begin
        hit_on  = (in_data == on1) || (in_data == on2);
        hit_off = (in_data == off1) || (in_data == off2);
      end
      default: ;
    endcase
  end

  always_comb begin
    if (seq_on) begin
      is_ctrl = (st_q != SQ_IDLE) || (in_data == on1) || (in_data == off1);
    end else begin
      is_ctrl = hit_on || hit_off;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q <= 1'b0;
      od_q <= '0;
    end else if (slot_free) begin
      ov_q <= miss || (take && !is_ctrl);
      od_q <= miss ? held_q : in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      held_q <= '0;
    end else if (!seq_on) begin
      st_q <= SQ_IDLE;
    end else if (miss && slot_free) begin
      st_q <= SQ_IDLE;
    end else if (take) begin
      unique case (st_q)
        SQ_IDLE: begin
          if (in_data == off1) begin
            st_q   <= SQ_OFF;
            held_q <= in_data;
          end else if (in_data == on1) begin
            st_q   <= SQ_ON;
            held_q <= in_data;
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_q <= 1'b0;
    end else if (mode == RXM_OFF) begin
      halt_q <= 1'b0;
    end else if (take) begin
      if (seq_on) begin
        if (st_q == SQ_ON)       halt_q <= 1'b0;
        else if (st_q == SQ_OFF) halt_q <= 1'b1;
      end else if (hit_off) begin
        halt_q <= 1'b1;
      end else if (hit_on) begin
        halt_q <= 1'b0;
      end
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;
  assign halt      = halt_q;

  AST_BYPASS_CLEARS_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_OFF) |=> !halt); // R1
  AST_SINGLE_OFF_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RXM_ONE && in_valid && in_ready && in_data == off1) |=> halt); // R2
  AST_FIRST_CHAR_NO_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_on && st_q == SQ_IDLE && in_valid && in_ready) |=> $stable(halt)); // R5
  AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (miss && slot_free) |=> (out_valid && out_data == $past(held_q))); // R6
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R7
  AST_BACKPRESSURE_STALLS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7
endmodule

// File: rtl/ifc_tx_arbiter.sv
module ifc_tx_arbiter
  import ifc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  tx_mode_e     mode,
  input  logic [W-1:0] on1,
  input  logic [W-1:0] on2,
  input  logic [W-1:0] off1,
  input  logic [W-1:0] off2,
  input  logic         req_on,
  input  logic         req_off,
  input  logic         halt,
  input  logic         fifo_valid,
  input  logic [W-1:0] fifo_data,
  output logic         fifo_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  input  logic         tx_ready
);
  logic         pend_q;
  logic         pend_off_q;
  logic         pend_2nd_q;
  logic [W-1:0] flow_chr;

  always_comb begin
    unique case (mode)
      TXM_TWO:  flow_chr = pend_off_q ? off2 : on2;
      TXM_PAIR: flow_chr = pend_2nd_q ? (pend_off_q ? off2 : on2)
                                      : (pend_off_q ? off1 : on1);
      default:  flow_chr = pend_off_q ? off1 : on1;
    endcase
  end

  assign tx_valid   = pend_q || (!halt && fifo_valid);
  assign tx_data    = pend_q ? flow_chr : fifo_data;
  assign fifo_ready = !pend_q && !halt && tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q     <= 1'b0;
      pend_off_q <= 1'b0;
      pend_2nd_q <= 1'b0;
    end else if (mode == TXM_OFF) begin
      pend_q     <= 1'b0;
      pend_2nd_q <= 1'b0;
    end else if (req_on || req_off) begin
      pend_q     <= 1'b1;
      pend_off_q <= req_off;
      pend_2nd_q <= 1'b0;
    end else if (pend_q && tx_ready) begin
      if (mode == TXM_PAIR && !pend_2nd_q) begin
        pend_2nd_q <= 1'b1;
      end else begin
        pend_q     <= 1'b0;
        pend_2nd_q <= 1'b0;
      end
    end
  end

  AST_HALT_BLOCKS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !pend_q) |-> (!tx_valid && !fifo_ready)); // R8
  AST_PAIR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TXM_PAIR && pend_q && !pend_2nd_q && tx_ready && !req_on && !req_off)
      |=> (pend_q && pend_2nd_q)); // R9
  AST_OFF_MODE_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == TXM_OFF) |=> !pend_q); // R9
  AST_FLOW_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (tx_valid && !fifo_ready)); // R10
endmodule

// File: rtl/inband_flow_ctrl.sv
module inband_flow_ctrl
  import ifc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [3:0]   cfg_mode,
  input  logic [W-1:0] on1_chr,
  input  logic [W-1:0] on2_chr,
  input  logic [W-1:0] off1_chr,
  input  logic [W-1:0] off2_chr,
  input  logic         rx_valid,
  input  logic [W-1:0] rx_data,
  output logic         rx_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready,
  input  logic         send_on_req,
  input  logic         send_off_req,
  input  logic         fifo_valid,
  input  logic [W-1:0] fifo_data,
  output logic         fifo_ready,
  output logic         tx_valid,
  output logic [W-1:0] tx_data,
  input  logic         tx_ready,
  output logic         tx_halt
);
  rx_mode_e rx_mode;
  tx_mode_e tx_mode;
  logic     pair_seq;
  logic     halt_w;

  assign rx_mode  = rx_mode_e'(cfg_mode[1:0]);
  assign tx_mode  = tx_mode_e'(cfg_mode[3:2]);
  assign pair_seq = (tx_mode == TXM_PAIR);

  ifc_rx_filter #(.W(W)) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (rx_mode),
    .pair_seq  (pair_seq),
    .on1       (on1_chr),
    .on2       (on2_chr),
    .off1      (off1_chr),
    .off2      (off2_chr),
    .in_valid  (rx_valid),
    .in_data   (rx_data),
    .in_ready  (rx_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready),
    .halt      (halt_w)
  );

  ifc_tx_arbiter #(.W(W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (tx_mode),
    .on1        (on1_chr),
    .on2        (on2_chr),
    .off1       (off1_chr),
    .off2       (off2_chr),
    .req_on     (send_on_req),
    .req_off    (send_off_req),
    .halt       (halt_w),
    .fifo_valid (fifo_valid),
    .fifo_data  (fifo_data),
    .fifo_ready (fifo_ready),
    .tx_valid   (tx_valid),
    .tx_data    (tx_data),
    .tx_ready   (tx_ready)
  );

  assign tx_halt = halt_w;

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !tx_halt)); // R11
endmodule

// File: tb/inband_flow_ctrl_test.sv
module inband_flow_ctrl_test;
  localparam int W  = 8;
  localparam int NV = 17;
  // vector: {cfg[3:0], byte[7:0], forwarded, halt_after}
  localparam logic [13:0] VEC [0:NV-1] = '{
    {4'h0, 8'h13, 1'b1, 1'b0},
    {4'h1, 8'h91, 1'b1, 1'b0},
    {4'h1, 8'h13, 1'b0, 1'b1},
    {4'h1, 8'h93, 1'b1, 1'b1},
    {4'h1, 8'h11, 1'b0, 1'b0},
    {4'h2, 8'h13, 1'b1, 1'b0},
    {4'h2, 8'h93, 1'b0, 1'b1},
    {4'h2, 8'h11, 1'b1, 1'b1},
    {4'h2, 8'h91, 1'b0, 1'b0},
    {4'h3, 8'h93, 1'b0, 1'b1},
    {4'h3, 8'h11, 1'b0, 1'b0},
    {4'h3, 8'h13, 1'b0, 1'b1},
    {4'h3, 8'h91, 1'b0, 1'b0},
    {4'h3, 8'h55, 1'b1, 1'b0},
    {4'h7, 8'h93, 1'b0, 1'b1},
    {4'h1, 8'h13, 1'b0, 1'b1},
    {4'h0, 8'h55, 1'b1, 1'b0}
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   cfg_mode = 4'h0;
  logic [W-1:0] on1_chr = 8'h11, on2_chr = 8'h91, off1_chr = 8'h13, off2_chr = 8'h93;
  logic         rx_valid = 1'b0;
  logic [W-1:0] rx_data = '0;
  logic         rx_ready;
  logic         out_valid;
  logic [W-1:0] out_data;
  logic         out_ready = 1'b1;
  logic         send_on_req = 1'b0, send_off_req = 1'b0;
  logic         fifo_valid = 1'b0;
  logic [W-1:0] fifo_data = 8'h5A;
  logic         fifo_ready;
  logic         tx_valid;
  logic [W-1:0] tx_data;
  logic         tx_ready = 1'b0;
  logic         tx_halt;

  int n_chk = 0;
  int n_bad = 0;
  logic [W-1:0] rxq[$];

  always #5 clk = ~clk;

  inband_flow_ctrl #(.W(W)) uut (.*);

  always @(negedge clk) if (rst_n && out_valid && out_ready) rxq.push_back(out_data);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [W-1:0] d);
    logic took;
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = d;
    do begin
      #1 took = rx_ready;
      @(posedge clk);
      @(negedge clk);
    end while (!took);
    rx_valid = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic pulse(input logic off);
    @(negedge clk);
    if (off) send_off_req = 1'b1; else send_on_req = 1'b1;
    @(negedge clk);
    send_on_req  = 1'b0;
    send_off_req = 1'b0;
    #1;
  endtask

  task automatic step_tx();
    @(negedge clk);
    tx_ready = 1'b1;
    @(negedge clk);
    tx_ready = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    string tg;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    // R11 reset state
    chk("R11 out_valid", out_valid, 0);
    chk("R11 tx_halt", tx_halt, 0);
    chk("R11 tx_valid", tx_valid, 0);

    // table walk: receive modes R1 R2 R3 R4
    for (int i = 0; i < NV; i++) begin
      cfg_mode = VEC[i][13:10];
      case (cfg_mode[1:0])
        2'b00:   tg = "R1";
        2'b01:   tg = "R2";
        2'b10:   tg = "R3";
        default: tg = "R4";
      endcase
      rxq.delete();
      send_byte(VEC[i][9:2]);
      settle();
      chk($sformatf("%s vec%0d forwarded", tg, i), rxq.size(), VEC[i][1]);
      if (VEC[i][1] && rxq.size() > 0)
        chk($sformatf("%s vec%0d data", tg, i), rxq[0], VEC[i][9:2]);
      chk($sformatf("%s vec%0d halt", tg, i), tx_halt, VEC[i][0]);
    end

    // R5 two-character sequences
    cfg_mode = 4'hF;
    rxq.delete();
    send_byte(8'h13);
    settle();
    chk("R5 first xoff alone halt", tx_halt, 0);
    chk("R5 first xoff held", rxq.size(), 0);
    send_byte(8'h93);
    settle();
    chk("R5 xoff pair halts", tx_halt, 1);
    send_byte(8'h11);
    send_byte(8'h91);
    settle();
    chk("R5 xon pair clears", tx_halt, 0);
    chk("R5 nothing forwarded", rxq.size(), 0);

    // R6 mismatch releases held byte
    rxq.delete();
    send_byte(8'h11);
    send_byte(8'h44);
    settle();
    chk("R6 release count", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk("R6 held first", rxq[0], 8'h11);
      chk("R6 new second", rxq[1], 8'h44);
    end
    send_byte(8'h13);
    send_byte(8'h93);
    settle();
    rxq.delete();
    send_byte(8'h13);
    send_byte(8'h11);
    send_byte(8'h91);
    settle();
    chk("R6 restart count", rxq.size(), 1);
    if (rxq.size() > 0) chk("R6 restart data", rxq[0], 8'h13);
    chk("R6 restart xon clears", tx_halt, 0);

    // R7 back-pressure
    cfg_mode = 4'h0;
    @(posedge clk);
    #1 out_ready = 1'b0;
    send_byte(8'h66);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = 8'h77;
    #1;
    chk("R7 rx_ready low", rx_ready, 0);
    chk("R7 out_valid", out_valid, 1);
    @(negedge clk);
    #1;
    chk("R7 data stable", out_data, 8'h66);
    @(posedge clk);
    #1;
    rxq.delete();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rx_valid = 1'b0;
    settle();
    chk("R7 drain count", rxq.size(), 2);
    if (rxq.size() == 2) begin
      chk("R7 drain first", rxq[0], 8'h66);
      chk("R7 drain second", rxq[1], 8'h77);
    end

    // R9 / R10 transmit insertion
    fifo_valid = 1'b1;
    cfg_mode = 4'b0100;
    pulse(1'b1);
    chk("R9 one-mode xoff", tx_data, 8'h13);
    chk("R10 fifo held back", fifo_ready, 0);
    step_tx();
    chk("R9 single char then fifo", tx_data, 8'h5A);
    cfg_mode = 4'b1000;
    pulse(1'b0);
    chk("R9 two-mode xon", tx_data, 8'h91);
    step_tx();
    cfg_mode = 4'b1100;
    pulse(1'b1);
    chk("R9 pair first", tx_data, 8'h13);
    step_tx();
    chk("R9 pair second", tx_data, 8'h93);
    step_tx();
    chk("R9 pair then fifo", tx_data, 8'h5A);
    cfg_mode = 4'b0000;
    pulse(1'b0);
    chk("R9 off mode ignores request", tx_data, 8'h5A);

    // R8 halt gating, R10 flow char during halt
    cfg_mode = 4'b0101;
    send_byte(8'h13);
    settle();
    chk("R8 halt set", tx_halt, 1);
    chk("R8 fifo blocked", tx_valid, 0);
    pulse(1'b0);
    chk("R10 flow char while halted valid", tx_valid, 1);
    chk("R10 flow char while halted data", tx_data, 8'h11);
    step_tx();
    chk("R8 blocked after flow char", tx_valid, 0);
    send_byte(8'h11);
    settle();
    chk("R8 resumes valid", tx_valid, 1);
    chk("R8 resumes data", tx_data, 8'h5A);

    finish_run();
  end
endmodule